// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block exposes a parameterised number of general-purpose pins (a multiple of 32) to software through a small 32-bit register bus. Each feature is held in a bank of 32-bit words, and the banks sit one after another in a fixed order. Software reads the synchronised pin levels and picks the direction of each pin. It drives output bits only through a write-one-to-set bank and a write-one-to-clear bank, so no read-modify-write is needed.

Every pin has its own rising-edge and falling-edge capture enables. An enabled edge latches a sticky status bit, and software clears that bit by writing 1 to it. The single interrupt line is high while any status bit is set. A 2-bit alternate-function select per pin is held in its own bank and driven out to the pad mux. A value of 0 means plain GPIO.

Bus reads are combinational and have no side effects. Writes take effect at the clock edge that samples `wr_en`.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: With W = NPIN/32, word r of bank t sits at byte address t*W*4 + r*4, and pin p is bit p%32 of word p/32. The banks are, in order: 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 edge status, 7 alternate function (2*W words). Addresses past the last bank read 0, and writes to them change nothing.
- R2: After reset the direction, output, both enables, status and alternate-function state are all zero, and `irq` is low.
- R3: Writing to the set bank drives high each `pad_out` bit written as 1 and leaves the other bits unchanged. The set bank reads 0.
- R4: Writing to the clear bank drives low each `pad_out` bit written as 1 and leaves the other bits unchanged. The clear bank reads 0.
- R5: A direction bit of 1 makes the pin an output (`pad_oe` high) and 0 makes it an input. The bank reads back what was written.
- R6: The level bank returns `pad_in` after a two-flop synchronizer, so it is visible two clocks after the change. Writes to it are ignored.
- R7: A rising edge on a pin latches its status bit when its rising enable is 1, and has no effect when the enable is 0.
- R8: A falling edge on a pin latches its status bit when its falling enable is 1, and has no effect when the enable is 0.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R10: An enabled edge that arrives after a clear is captured again. An edge that is detected in the same cycle as a clear of that bit keeps the bit set.
- R11: `irq` is high exactly when at least one status bit is set.
- R12: The alternate-function select for pin p is 2 bits wide, at bit (p%16)*2 of word p/16 of bank 7. It reads back and drives `alt_sel[2p+1:2p]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pad_in | input | NPIN | Pin inputs from the pads |
| pad_out | output | NPIN | Output levels to the pads |
| pad_oe | output | NPIN | Output enables to the pads |
| alt_sel | output | 2*NPIN | Alternate-function selects, 2 bits per pin |
| irq | output | 1 | Level interrupt, OR of the status bits |

## Verification
The assertions assume that `pad_in` changes only between clock edges, and that there is at most one bus write per cycle, so a set and a clear never land together. The same-cycle priority check assumes that the decoded clear mask and the edge-hit vector come from the current write and the current synchronised sample. The stimulus changes pins shortly after a rising edge and issues writes one at a time. It also times one status clear so that the clock edge that samples it is the one that would latch a new falling edge, which exercises the new-edge-wins case directly.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int NPIN   = 64,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  input  logic [NPIN-1:0]     pad_in,
  output logic [NPIN-1:0]     pad_out,
  output logic [NPIN-1:0]     pad_oe,
  output logic [2*NPIN-1:0]   alt_sel,
  output logic                irq
);
  localparam int W     = NPIN / 32;
  localparam int NBANK = 8;
  localparam int ALT_T = 7;

  logic [NPIN-1:0]   sync1, sync2, prev;
  logic [NPIN-1:0]   dir_q, out_q, rise_q, fall_q, stat_q;
  logic [2*NPIN-1:0] alt_q;
  logic [NPIN-1:0]   edge_hit, wr_bits, wvec, clr_mask;
  logic [2*NPIN-1:0] alt_bits, alt_wvec;
  logic [3:0]        sel_t;
  logic [7:0]        sel_w;
  logic [ADDR_W-3:0] widx;

  assign widx = addr[ADDR_W-1:2];

  always_comb begin
    sel_t = 4'd8;
    sel_w = '0;
    for (int t = 0; t < NBANK; t++) begin
      if (int'(widx) >= t*W && int'(widx) < t*W + ((t == ALT_T) ? 2*W : W)) begin
        sel_t = 4'(t);
        sel_w = 8'(int'(widx) - t*W);
      end
    end
  end

  assign wvec     = {W{wdata}};
  assign alt_wvec = {(2*W){wdata}};

  for (genvar g = 0; g < W; g++) begin : g_wsel
    assign wr_bits[g*32 +: 32] = {32{wr_en && sel_w == 8'(g)}};
  end
  for (genvar g = 0; g < 2*W; g++) begin : g_asel
    assign alt_bits[g*32 +: 32] = {32{wr_en && sel_t == 4'(ALT_T) && sel_w == 8'(g)}};
  end

  assign edge_hit = (sync2 & ~prev & rise_q) | (~sync2 & prev & fall_q);
  assign clr_mask = (sel_t == 4'd6) ? (wvec & wr_bits) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      prev   <= '0;
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
      alt_q  <= '0;
    end else begin
      sync1  <= pad_in;
      sync2  <= sync1;
      prev   <= sync2;
      stat_q <= (stat_q & ~clr_mask) | edge_hit;
      alt_q  <= (alt_q & ~alt_bits) | (alt_wvec & alt_bits);
      case (sel_t)
        4'd1: dir_q  <= (dir_q & ~wr_bits) | (wvec & wr_bits);
        4'd2: out_q  <= out_q | (wvec & wr_bits);
        4'd3: out_q  <= out_q & ~(wvec & wr_bits);
        4'd4: rise_q <= (rise_q & ~wr_bits) | (wvec & wr_bits);
        4'd5: fall_q <= (fall_q & ~wr_bits) | (wvec & wr_bits);
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel_t)
      4'd0:    rdata = sync2[32*sel_w +: 32];
      4'd1:    rdata = dir_q[32*sel_w +: 32];
      4'd4:    rdata = rise_q[32*sel_w +: 32];
      4'd5:    rdata = fall_q[32*sel_w +: 32];
      4'd6:    rdata = stat_q[32*sel_w +: 32];
      4'd7:    rdata = alt_q[32*sel_w +: 32];
      default: rdata = '0;
    endcase
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
  assign alt_sel = alt_q;
  assign irq     = |stat_q;

  logic [NPIN-1:0] set_hit, clr_hit;
  assign set_hit = (sel_t == 4'd2) ? (wvec & wr_bits) : '0;
  assign clr_hit = (sel_t == 4'd3) ? (wvec & wr_bits) : '0;

  // R3
  set_drives_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_hit) |=> ((pad_out & $past(set_hit)) == $past(set_hit)));

  // R4
  clr_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_hit) |=> ((pad_out & $past(clr_hit)) == '0));

  // R5
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel_t == 4'd1) |=> $stable(pad_oe));

  // R7
  status_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(edge_hit)) == '0));

  // R10
  edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & edge_hit)) |=> ((stat_q & $past(clr_mask & edge_hit)) == $past(clr_mask & edge_hit)));

  // R11
  irq_low_when_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(irq) && $past(edge_hit) == '0) |-> !irq);
endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;
  localparam int NPIN = 64;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              wr_en = 0;
  logic [7:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NPIN-1:0]   pad_in = '0;
  logic [NPIN-1:0]   pad_out, pad_oe;
  logic [2*NPIN-1:0] alt_sel;
  logic              irq;

  gpio_bank_ctrl #(.NPIN(NPIN), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_sel(alt_sel), .irq(irq)
  );

  always #5 clk = ~clk;

  typedef struct {
    int          src;
    int          w;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  logic  chk_vld = 0;
  logic  done = 0;

  always @(negedge clk) begin
    if (chk_vld && q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.src)
        0: act = rdata;
        1: act = pad_out[it.w*32 +: 32];
        2: act = pad_oe[it.w*32 +: 32];
        3: act = {31'd0, irq};
        default: act = alt_sel[it.w*32 +: 32];
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #2;
    wr_en = 0;
  endtask

  task automatic expect_obs(input int src, input int w, input logic [7:0] a,
                            input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #2;
    addr = a;
    it.src = src; it.w = w; it.exp = e; it.tag = tag;
    q.push_back(it);
    chk_vld = 1;
    @(negedge clk); #1;
    chk_vld = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    expect_obs(0, 0, a, e, tag);
  endtask

  task automatic set_pad(input logic [NPIN-1:0] v);
    @(posedge clk); #2;
    pad_in = v;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    rd(8'd8,  32'h0, "R2 dir reset");
    rd(8'd48, 32'h0, "R2 status reset");
    rd(8'd56, 32'h0, "R2 alt reset");
    expect_obs(1, 0, 8'd0, 32'h0, "R2 pad_out reset");
    expect_obs(3, 0, 8'd0, 32'h0, "R2 irq reset");

    wr(8'd8,  32'h0000_00F0);
    wr(8'd12, 32'h8000_0001);
    expect_obs(2, 0, 8'd0, 32'h0000_00F0, "R5 pad_oe word0");
    expect_obs(2, 1, 8'd0, 32'h8000_0001, "R5 pad_oe word1");
    rd(8'd12, 32'h8000_0001, "R5 dir readback");

    wr(8'd16, 32'h0000_000F);
    expect_obs(1, 0, 8'd0, 32'h0000_000F, "R3 set word0");
    wr(8'd16, 32'h0000_0100);
    expect_obs(1, 0, 8'd0, 32'h0000_010F, "R3 zero bits keep");
    rd(8'd16, 32'h0, "R3 set reads zero");
    wr(8'd20, 32'h8000_0000);
    expect_obs(1, 1, 8'd0, 32'h8000_0000, "R3 set word1");

    wr(8'd24, 32'h0000_0003);
    expect_obs(1, 0, 8'd0, 32'h0000_010C, "R4 clear word0");
    rd(8'd24, 32'h0, "R4 clear reads zero");

    set_pad(64'hA5A5_0000_0000_1234);
    rd(8'd0, 32'h0000_1234, "R6 level word0");
    rd(8'd4, 32'hA5A5_0000, "R6 level word1");
    wr(8'd0, 32'hFFFF_FFFF);
    rd(8'd0, 32'h0000_1234, "R6 level ignores write");

    set_pad('0);
    wr(8'd32, 32'h0000_0001);
    wr(8'd40, 32'h0000_0002);
    set_pad(64'h3);
    rd(8'd48, 32'h0000_0001, "R7 rise only when enabled");
    expect_obs(3, 0, 8'd0, 32'h1, "R11 irq high");

    wr(8'd48, 32'h0000_0001);
    rd(8'd48, 32'h0, "R9 w1c clears");
    expect_obs(3, 0, 8'd0, 32'h0, "R11 irq low");
    set_pad('0);
    rd(8'd48, 32'h0000_0002, "R8 fall only when enabled");

    wr(8'd48, 32'h0);
    rd(8'd48, 32'h0000_0002, "R9 write zero no effect");
    wr(8'd48, 32'h0000_0002);
    rd(8'd48, 32'h0, "R9 clear bit1");

    set_pad(64'h1);
    wr(8'd48, 32'h1);
    rd(8'd48, 32'h0, "R10 cleared");
    set_pad('0);
    set_pad(64'h1);
    rd(8'd48, 32'h0000_0001, "R10 edge recaptured");

    set_pad(64'h3);
    @(posedge clk); #2;
    pad_in = 64'h1;
    @(posedge clk);
    wr(8'd48, 32'h0000_0002);
    rd(8'd48, 32'h0000_0003, "R10 edge wins over clear");
    wr(8'd48, 32'h0000_0003);
    rd(8'd48, 32'h0, "R10 cleared after");

    wr(8'd36, 32'h8000_0000);
    set_pad(64'h8000_0000_0000_0001);
    rd(8'd52, 32'h8000_0000, "R1 status word1 pin63");
    expect_obs(3, 0, 8'd0, 32'h1, "R11 irq from word1");

    wr(8'd60, 32'h0000_000E);
    expect_obs(4, 1, 8'd0, 32'h0000_000E, "R12 alt pins16-17");
    rd(8'd60, 32'h0000_000E, "R12 alt readback");
    wr(8'd68, 32'h4000_0000);
    expect_obs(4, 3, 8'd0, 32'h4000_0000, "R12 alt pin63");

    wr(8'd72, 32'hFFFF_FFFF);
    rd(8'd72, 32'h0, "R1 unmapped reads zero");
    rd(8'd8, 32'h0000_00F0, "R1 unmapped write ignored");

    repeat (2) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule